// File: doc/BRIEF.md
# Mark-Retransmit FIFO with Fill-State Flags

This block is a first-in first-out store of 9-bit words with a depth set by a parameter; deployments use 8192, 16384 or 32768 words. Words come out in the order they went in. Writing and reading are triggered by two active-low strobes. Each strobe is sampled on the block clock, and only its falling edge counts: the first clock on which a strobe is seen LOW after being seen HIGH. Holding a strobe LOW does nothing more. Flow control uses the flags rather than a handshake. A write arriving while the store is full is dropped, and so is a read arriving while it is empty, so the producer must watch the full state and the consumer the empty state.

A level-sensitive mark input saves the current read position. A falling edge on the retransmit strobe moves the read position back to the saved one, so words already delivered are delivered again, and the word count grows to match. Three active-low status pins together encode six fill states. One of them uses a programmable offset for its almost-empty and almost-full thresholds. An asynchronous active-low master reset clears the pointers and the mark, and restores the offset to one eighth of the depth. After each master reset, the first write strobe loads the offset from the data inputs instead of storing a word. The first read strobe returns the offset on the data output instead of taking a word. The data output is meant to be driven onto a shared bus only while the read strobe is LOW, and an enable output says when.

Top module: `mark_fifo`

## Requirements
- R1: Words are 9 bits wide and at most DEPTH are held (DEPTH a power of two, at least 512). Words are read out in the order written, and the held count never exceeds DEPTH.
- R2: A write happens on the clock edge where `wr_n` is sampled LOW after being sampled HIGH on the previous edge. Keeping `wr_n` LOW for more edges stores nothing further.
- R3: A write strobe that arrives while DEPTH words are held is ignored. The count stays DEPTH and no held word changes.
- R4: A read happens on the falling edge of `rd_n`. At that same clock edge, `dout` takes the oldest held word. A read strobe that arrives while nothing is held is ignored, and `dout` keeps its value.
- R5: `dout_oe` is 1 exactly while `rd_n` is LOW.
- R6: On every clock edge where `mark` is 1, the current read position (taken before any read on that edge) is saved. After master reset the saved position is the start.
- R7: A falling edge on `rt_n` sets the read position to the saved one, and the count becomes the number of words written since that position. A read strobe falling on the same edge is dropped.
- R8: With `count` as the held word count, the pins {`ef_n`,`pafe_n`,`hf_n`} read as follows: empty = 0,0,1; almost empty = 1,0,1; at or below half = 1,1,1; above half = 1,1,0; almost full = 1,0,0; full = 0,0,0. Here `hf_n` is 0 exactly when count > DEPTH/2.
- R9: `pafe_n` is 0 exactly when count <= offset or count >= DEPTH - offset. After master reset the offset is DEPTH/8.
- R10: While `mr_n` is LOW, both pointers, the mark and `dout` are held at zero, `ef_n` is 0, and the offset returns to DEPTH/8.
- R11: The first write strobe after master reset loads `din`, zero-extended, into the offset and stores no word.
- R12: The first read strobe after master reset puts the low 9 bits of the offset on `dout` and moves no pointer.
- R13: When read and write strobes fall on the same edge, both take effect, with two exceptions. If the store is empty, only the write happens. If it is full, only the read happens.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled on its rising edge |
| mr_n | input | 1 | Master reset, active LOW, asynchronous |
| wr_n | input | 1 | Write strobe, active LOW, falling edge counts |
| rd_n | input | 1 | Read strobe, active LOW, falling edge counts |
| mark | input | 1 | Save the read position while 1 |
| rt_n | input | 1 | Retransmit strobe, active LOW, falling edge counts |
| din | input | 9 | Word to write, or offset value on the first write after reset |
| dout | output | 9 | Last word read, or the offset on the first read after reset |
| dout_oe | output | 1 | Output enable for `dout`; 1 while `rd_n` is LOW |
| ef_n | output | 1 | LOW when empty or full |
| pafe_n | output | 1 | LOW when almost empty or almost full |
| hf_n | output | 1 | LOW when more than half full |

## Verification
Two functions can meet on one edge. The first pair is a read and a write. On an empty store, the simultaneous write must be kept and the read dropped with `dout` unchanged. On a full store, the write must be dropped and the read served. The bench provokes both cases by lowering the two strobes together right after filling the store to DEPTH and right after draining it. The second pair is a retransmit and a read, which the bench lowers together in mid-stream; the read must vanish and the next read must return the marked word. A cycle-by-cycle queue model judges every pin on every clock, and explicit checks pin down the returned words and the flag codes.

// File: rtl/mark_fifo_pkg.sv
package mark_fifo_pkg;
  localparam int WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;

  // Pin code {ef_n, pafe_n, hf_n} from the three fill conditions.
  function automatic logic [2:0] flag_code(input logic at_edge,
                                           input logic near,
                                           input logic over_half);
    return {~at_edge, ~near, ~over_half};
  endfunction
endpackage

// File: rtl/mark_fifo_edge.sv
module mark_fifo_edge #(
  parameter int IDLE = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_n,
  output logic fall
);
  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'(IDLE);
    else        last_q <= strobe_n;
  end

  assign fall = last_q & ~strobe_n;
endmodule

// File: rtl/mark_fifo_ram.sv
module mark_fifo_ram
  import mark_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/mark_fifo_flags.sv
module mark_fifo_flags
  import mark_fifo_pkg::*;
#(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] offset,
  output logic          ef_n,
  output logic          pafe_n,
  output logic          hf_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic is_empty, is_full, near_low, near_high, over_half;

  always_comb begin
    is_empty  = (count == '0);
    is_full   = (count == FULL_CNT);
    near_low  = (count <= offset);
    near_high = (count >= (FULL_CNT - offset));
    over_half = (count > HALF_CNT);
    {ef_n, pafe_n, hf_n} = flag_code(is_empty | is_full,
                                     near_low | near_high,
                                     over_half);
  end
endmodule

// File: rtl/mark_fifo.sv
module mark_fifo
  import mark_fifo_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       mr_n,
  input  logic       wr_n,
  input  logic       rd_n,
  input  logic       mark,
  input  logic       rt_n,
  input  logic [8:0] din,
  output logic [8:0] dout,
  output logic       dout_oe,
  output logic       ef_n,
  output logic       pafe_n,
  output logic       hf_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] DEF_OFS  = CW'(DEPTH / 8);

  logic wr_ev, rd_ev, rt_ev;
  logic [CW-1:0] wr_ptr, rd_ptr, mark_ptr, ofs_q, count;
  logic wr_prog, rd_prog;
  logic is_full, is_empty;
  logic do_store, do_pop, do_peek;
  word_t ram_rdata;

  mark_fifo_edge u_wr_edge (.clk(clk), .rst_n(mr_n), .strobe_n(wr_n), .fall(wr_ev));
  mark_fifo_edge u_rd_edge (.clk(clk), .rst_n(mr_n), .strobe_n(rd_n), .fall(rd_ev));
  mark_fifo_edge u_rt_edge (.clk(clk), .rst_n(mr_n), .strobe_n(rt_n), .fall(rt_ev));

  assign count    = wr_ptr - rd_ptr;
  assign is_full  = (count == FULL_CNT);
  assign is_empty = (count == '0);

  assign do_store = wr_ev & ~wr_prog & ~is_full;
  assign do_pop   = rd_ev & ~rt_ev & ~rd_prog & ~is_empty;
  assign do_peek  = rd_ev & ~rt_ev & rd_prog;

  mark_fifo_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_store),
    .waddr (wr_ptr[AW-1:0]),
    .wdata (din),
    .raddr (rd_ptr[AW-1:0]),
    .rdata (ram_rdata)
  );

  always_ff @(posedge clk or negedge mr_n) begin
    if (!mr_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      mark_ptr <= '0;
      ofs_q    <= DEF_OFS;
      wr_prog  <= 1'b1;
      rd_prog  <= 1'b1;
      dout     <= '0;
    end else begin
      if (do_store) wr_ptr <= wr_ptr + 1'b1;
      if (wr_ev && wr_prog) begin
        ofs_q   <= CW'(din);
        wr_prog <= 1'b0;
      end
      if (rt_ev)       rd_ptr <= mark_ptr;
      else if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      if (do_peek) rd_prog <= 1'b0;
      if (mark) mark_ptr <= rd_ptr;
      if (do_pop)       dout <= ram_rdata;
      else if (do_peek) dout <= ofs_q[8:0];
    end
  end

  assign dout_oe = ~rd_n;

  mark_fifo_flags #(.DEPTH(DEPTH)) u_flags (
    .count  (count),
    .offset (ofs_q),
    .ef_n   (ef_n),
    .pafe_n (pafe_n),
    .hf_n   (hf_n)
  );
endmodule

// File: rtl/mark_fifo_chk.sv
module mark_fifo_chk #(
  parameter int DEPTH = 1024,
  localparam int CW = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          mr_n,
  input logic          wr_ev,
  input logic          rd_ev,
  input logic          rt_ev,
  input logic          mark,
  input logic          wr_prog,
  input logic          rd_prog,
  input logic [CW-1:0] wr_ptr,
  input logic [CW-1:0] rd_ptr,
  input logic [CW-1:0] mark_ptr,
  input logic [CW-1:0] count,
  input logic [CW-1:0] ofs_q,
  input logic [8:0]    dout,
  input logic          ef_n,
  input logic          pafe_n,
  input logic          hf_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!mr_n)
    count <= FULL_CNT);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!mr_n)
    (wr_ev && !wr_prog && count == FULL_CNT) |=> $stable(wr_ptr));

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!mr_n)
    (rd_ev && !rt_ev && !rd_prog && count == '0) |=> ($stable(rd_ptr) && $stable(dout)));

  p_mark_save_r6: assert property (@(posedge clk) disable iff (!mr_n)
    mark |=> (mark_ptr == $past(rd_ptr)));

  p_rewind_r7: assert property (@(posedge clk) disable iff (!mr_n)
    rt_ev |=> (rd_ptr == $past(mark_ptr)));

  p_full_code_r8: assert property (@(posedge clk) disable iff (!mr_n)
    (count == FULL_CNT) |-> (!ef_n && !pafe_n && !hf_n));

  p_empty_code_r8: assert property (@(posedge clk) disable iff (!mr_n)
    (count == '0) |-> (!ef_n && !pafe_n && hf_n));

  p_reset_state_r10: assert property (@(posedge clk) disable iff (!mr_n)
    $rose(mr_n) |-> (wr_ptr == '0 && rd_ptr == '0 && mark_ptr == '0 && !ef_n));

  p_offset_load_r11: assert property (@(posedge clk) disable iff (!mr_n)
    (wr_ev && wr_prog) |=> ($stable(wr_ptr) && !wr_prog));

  p_offset_peek_r12: assert property (@(posedge clk) disable iff (!mr_n)
    (rd_ev && !rt_ev && rd_prog) |=> (dout == $past(ofs_q[8:0]) && $stable(rd_ptr)));
endmodule

bind mark_fifo mark_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .mr_n     (mr_n),
  .wr_ev    (wr_ev),
  .rd_ev    (rd_ev),
  .rt_ev    (rt_ev),
  .mark     (mark),
  .wr_prog  (wr_prog),
  .rd_prog  (rd_prog),
  .wr_ptr   (wr_ptr),
  .rd_ptr   (rd_ptr),
  .mark_ptr (mark_ptr),
  .count    (count),
  .ofs_q    (ofs_q),
  .dout     (dout),
  .ef_n     (ef_n),
  .pafe_n   (pafe_n),
  .hf_n     (hf_n)
);

// File: tb/sim_mark_fifo.sv
module sim_mark_fifo;
  localparam int DEPTH = 1024;
  localparam int HALF  = DEPTH / 2;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic mr_n = 1'b0, wr_n = 1'b1, rd_n = 1'b1, mark = 1'b0, rt_n = 1'b1;
  logic [8:0] din = '0;
  logic [8:0] dout;
  logic dout_oe, ef_n, pafe_n, hf_n;

  mark_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .mr_n(mr_n), .wr_n(wr_n), .rd_n(rd_n), .mark(mark), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe), .ef_n(ef_n), .pafe_n(pafe_n), .hf_n(hf_n)
  );

  int checks = 0;
  int fails  = 0;

  // Behavioural reference: every word ever written, absolute read index.
  int hist[$];
  int rp, mk, ofs_m, dout_m;
  bit wprog, rprog, pw, pr, pt;

  function automatic int held();
    return hist.size() - rp;
  endfunction

  task automatic model_reset();
    hist.delete();
    rp = 0; mk = 0; ofs_m = DEPTH / 8; dout_m = 0;
    wprog = 1; rprog = 1; pw = 1; pr = 1; pt = 1;
  endtask

  task automatic model_edge();
    bit wev, rev, tev;
    int n, nrp;
    if (!mr_n) begin
      model_reset();
      return;
    end
    wev = pw && !wr_n; rev = pr && !rd_n; tev = pt && !rt_n;
    pw = wr_n; pr = rd_n; pt = rt_n;
    n = held();
    nrp = rp;
    if (wev) begin
      if (wprog) begin ofs_m = int'(din); wprog = 0; end
      else if (n < DEPTH) hist.push_back(int'(din));
    end
    if (tev) nrp = mk;
    else if (rev) begin
      if (rprog) begin dout_m = ofs_m % 512; rprog = 0; end
      else if (n > 0) begin dout_m = hist[rp]; nrp = rp + 1; end
    end
    if (mark) mk = rp;
    rp = nrp;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare();
    int n;
    bit near;
    n = held();
    near = (n <= ofs_m) || (n >= DEPTH - ofs_m);
    check("R8", "ef_n", int'(ef_n), (n == 0 || n == DEPTH) ? 0 : 1);
    check("R9", "pafe_n", int'(pafe_n), near ? 0 : 1);
    check("R8", "hf_n", int'(hf_n), (n > HALF) ? 0 : 1);
    check("R4", "dout", int'(dout), dout_m);
    check("R5", "dout_oe", int'(dout_oe), rd_n ? 0 : 1);
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare();
  endtask

  task automatic wr(int w);
    din = 9'(w); wr_n = 1'b0; step();
    wr_n = 1'b1; step();
  endtask

  task automatic rd();
    rd_n = 1'b0; step();
    rd_n = 1'b1; step();
  endtask

  task automatic both(int w);
    din = 9'(w); wr_n = 1'b0; rd_n = 1'b0; step();
    wr_n = 1'b1; rd_n = 1'b1; step();
  endtask

  task automatic master_reset();
    mr_n = 1'b0; step(); step();
    mr_n = 1'b1; step();
  endtask

  function automatic int fill_word(int i);
    return (i * 37 + 5) % 512;
  endfunction

  initial begin
    model_reset();
    step(); step();
    // R10: reset state on the pins
    check("R10", "ef_n in reset", int'(ef_n), 0);
    check("R10", "dout in reset", int'(dout), 0);
    mr_n = 1'b1; step();

    // R9 / R12: first read returns the default offset DEPTH/8
    rd();
    check("R9", "default offset readback", int'(dout), DEPTH / 8);

    // R10 / R11: new reset, then program offset 100; no word stored
    master_reset();
    wr(100);
    check("R11", "ef_n after offset write", int'(ef_n), 0);
    rd();
    check("R12", "offset readback", int'(dout), 100);
    rd();
    check("R4", "dout after read on empty", int'(dout), 100);

    // R2: strobe held low stores only one word
    din = 9'd7; wr_n = 1'b0;
    for (int i = 0; i < 4; i++) step();
    wr_n = 1'b1; step();
    rd();
    check("R2", "single stored word", int'(dout), 7);
    check("R2", "empty after one read", int'(ef_n), 0);

    // R1: order
    for (int i = 0; i < 10; i++) wr(10 + i);
    for (int i = 0; i < 3; i++) begin
      rd();
      check("R1", "order", int'(dout), 10 + i);
    end

    // R6 / R7: mark at word 13, read two, rewind
    mark = 1'b1; step(); mark = 1'b0; step();
    rd(); rd();
    check("R1", "word before rewind", int'(dout), 14);
    rt_n = 1'b0; step(); rt_n = 1'b1; step();
    rd();
    check("R7", "replay after rewind", int'(dout), 13);
    // R7: rewind and read together, read dropped
    rt_n = 1'b0; rd_n = 1'b0; step();
    rt_n = 1'b1; rd_n = 1'b1; step();
    check("R7", "dout unchanged by dropped read", int'(dout), 13);
    rd();
    check("R7", "marked word again", int'(dout), 13);
    while (held() > 0) rd();

    // R3: fill past full
    for (int i = 0; i < DEPTH + 2; i++) wr(fill_word(i));
    check("R3", "ef_n when full", int'(ef_n), 0);
    check("R3", "hf_n when full", int'(hf_n), 0);
    // R13: read and write together while full: write dropped
    both(300);
    check("R13", "read served at full", int'(dout), fill_word(0));
    check("R13", "no longer full", int'(ef_n), 1);
    both(301);
    check("R13", "both taken mid-fill", int'(dout), fill_word(1));
    rd();
    check("R3", "no word overwritten", int'(dout), fill_word(2));
    while (held() > 0) rd();
    check("R8", "empty code ef_n", int'(ef_n), 0);
    // R13: read and write together while empty: read dropped
    both(55);
    check("R13", "write kept at empty", int'(ef_n), 1);
    check("R13", "dout unchanged at empty", int'(dout), 301);
    rd();
    check("R13", "kept word", int'(dout), 55);

    // R10: reset mid-stream clears count
    wr(1); wr(2);
    master_reset();
    check("R10", "ef_n after reset", int'(ef_n), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule